// File: doc/BRIEF.md
# Host-Triggered Output Compare Channel

This block is one output compare channel of a timer unit. A host sets it up through a small set of write-only parameter registers. It then starts work by writing a 2-bit request code. The channel compares one of two free-running 16-bit timebases, supplied at its inputs, against a scheduled match time. When the two are equal, it acts on an output pin and pulses an interrupt.

The request code picks the mode.

- **Single-pulse request:** the channel takes a snapshot of both timebases. It then arms one match at the reference time plus the offset.
- **Snapshot-only request:** a control bit reduces the single-pulse request to the snapshot and an interrupt, with no match armed.
- **Continuous request:** the channel arms the same first match. After each match it re-arms itself one period later and toggles the pin every time.

The channel records the timebase value at each match. It clears the request field once the request has been taken up, so the host can poll for 00 before it writes again.

Top module: `oc_channel`

## Requirements
- R1: After reset the request field, pin, interrupt, both snapshots and the match-time record are all 0, and no match is armed.
- R2: A write of the request register (address 4, code in bits 1:0) is accepted only while the field reads 00 and is otherwise ignored. Code 01 is a single-pulse request, 11 is a continuous request, and 10 is cleared with no other effect.
- R3: With a nonzero priority, a request written at one clock edge is taken up at the next edge, and the field reads 00 from then on.
- R4: While the priority (control register address 0, bits 5:4) is 00, a pending request stays in the field. It is taken up at the first edge after the priority becomes nonzero.
- R5: When a single-pulse request is taken up, the timebase values present at that edge are copied into snapshot 1 (first timebase) and snapshot 2 (second timebase).
- R6: A single-pulse request with control bit 3 clear arms one match at (reference, address 2, plus offset, address 1) modulo 2^16. At the match the timebase value is recorded, the interrupt is high for exactly one cycle after that edge, and the channel disarms.
- R7: A single-pulse request with control bit 3 set only takes the snapshots and pulses the interrupt one cycle after take-up. No match is armed.
- R8: A continuous request arms its first match at reference plus offset. Each later match is armed at the previous match time plus the period (address 3), modulo 2^16. Every match toggles the pin and pulses the interrupt.
- R9: On a single-pulse match the pin follows control bits 1:0: 00 unchanged, 01 driven high, 10 driven low, 11 toggled.
- R10: When a request that arms a new match is taken up in the same cycle as a match on the old schedule, the old match is dropped. No interrupt, pin change or time record results from it, and the new schedule is armed.
- R11: Control bit 2 selects the compared timebase: 0 for the first, 1 for the second. Equality on the unselected timebase causes no match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host register address |
| wr_data | input | 16 | Host write data |
| tcr1 | input | 16 | First free-running timebase |
| tcr2 | input | 16 | Second free-running timebase |
| req_o | output | 2 | Request field as seen by the host |
| snap1_o | output | 16 | First timebase snapshot |
| snap2_o | output | 16 | Second timebase snapshot |
| match_time_o | output | 16 | Timebase value at the last match |
| pin_o | output | 1 | Compare output pin |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Taking up a new request and a match on the pending schedule can fall on the same clock edge, because requests may be issued while a continuous schedule is running. The bench provokes this by letting a continuous schedule run, then writing a single-pulse request. It drives the selected timebase to the old compare value exactly at the take-up edge. It then requires that no interrupt and no pin change follow that edge, and that the interrupt comes only when the timebase reaches the newly computed match time.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam logic [1:0] REQ_NONE   = 2'b00;
  localparam logic [1:0] REQ_SINGLE = 2'b01;
  localparam logic [1:0] REQ_RSVD   = 2'b10;
  localparam logic [1:0] REQ_CONT   = 2'b11;

  localparam logic [1:0] ACT_KEEP   = 2'b00;
  localparam logic [1:0] ACT_HIGH   = 2'b01;
  localparam logic [1:0] ACT_LOW    = 2'b10;
  localparam logic [1:0] ACT_TOGGLE = 2'b11;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_OFFSET = 3'd1;
  localparam logic [2:0] ADDR_REF    = 3'd2;
  localparam logic [2:0] ADDR_PERIOD = 3'd3;
  localparam logic [2:0] ADDR_REQ    = 3'd4;

  typedef struct packed {
    logic [1:0] prio;
    logic       snap_only;
    logic       tb_sel;
    logic [1:0] act;
  } ctrl_t;
endpackage

// File: rtl/oc_regs.sv
module oc_regs
  import oc_pkg::*;
#(
  parameter int TW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW-1:0] wr_data,
  input  logic          req_take,
  output ctrl_t         ctrl,
  output logic [TW-1:0] offset,
  output logic [TW-1:0] ref_time,
  output logic [TW-1:0] period,
  output logic [1:0]    req
);
  localparam int CW = $bits(ctrl_t);

  logic sel_ctrl, sel_off, sel_ref, sel_per, sel_req, req_accept;

  assign sel_ctrl   = wr_en && (wr_addr == AW'(ADDR_CTRL));
  assign sel_off    = wr_en && (wr_addr == AW'(ADDR_OFFSET));
  assign sel_ref    = wr_en && (wr_addr == AW'(ADDR_REF));
  assign sel_per    = wr_en && (wr_addr == AW'(ADDR_PERIOD));
  assign sel_req    = wr_en && (wr_addr == AW'(ADDR_REQ));
  assign req_accept = sel_req && (req == REQ_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      offset   <= '0;
      ref_time <= '0;
      period   <= '0;
      req      <= REQ_NONE;
    end else begin
      if (sel_ctrl) ctrl     <= ctrl_t'(wr_data[CW-1:0]);
      if (sel_off)  offset   <= wr_data;
      if (sel_ref)  ref_time <= wr_data;
      if (sel_per)  period   <= wr_data;
      if (req_take)        req <= REQ_NONE;
      else if (req_accept) req <= wr_data[1:0];
    end
  end

  AST_REQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> (req == REQ_NONE)); // R3

  AST_REQ_HELD_NO_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (req != REQ_NONE && ctrl.prio == 2'b00) |=> (req == $past(req))); // R4

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && req != REQ_NONE && !req_take) |=> (req == $past(req))); // R2
endmodule

// File: rtl/oc_sched.sv
module oc_sched
  import oc_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [TW-1:0] offset,
  input  logic [TW-1:0] ref_time,
  input  logic [TW-1:0] period,
  input  logic [1:0]    req,
  input  logic [TW-1:0] tcr1,
  input  logic [TW-1:0] tcr2,
  output logic          req_take,
  output logic          hit,
  output logic          cont,
  output logic [TW-1:0] snap1,
  output logic [TW-1:0] snap2,
  output logic [TW-1:0] match_time,
  output logic          irq
);
  function automatic logic [TW-1:0] add_mod(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return a + b;
  endfunction

  logic          armed;
  logic [TW-1:0] cmp;
  logic [TW-1:0] tb_now;
  logic          take_single, snap_event, load_event;

  assign req_take    = (req != REQ_NONE) && (ctrl.prio != 2'b00);
  assign take_single = req_take && (req == REQ_SINGLE);
  assign snap_event  = take_single && ctrl.snap_only;
  assign load_event  = req_take && ((req == REQ_CONT) || (req == REQ_SINGLE && !ctrl.snap_only));
  assign tb_now      = ctrl.tb_sel ? tcr2 : tcr1;
  assign hit         = armed && (tb_now == cmp) && !load_event;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      cont       <= 1'b0;
      cmp        <= '0;
      snap1      <= '0;
      snap2      <= '0;
      match_time <= '0;
      irq        <= 1'b0;
    end else begin
      irq <= hit || snap_event;
      if (take_single) begin
        snap1 <= tcr1;
        snap2 <= tcr2;
      end
      if (load_event) begin
        cmp   <= add_mod(ref_time, offset);
        armed <= 1'b1;
        cont  <= (req == REQ_CONT);
      end else if (hit) begin
        match_time <= tb_now;
        if (cont) cmp <= add_mod(cmp, period);
        else      armed <= 1'b0;
      end
    end
  end

  AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    take_single |=> (snap1 == $past(tcr1) && snap2 == $past(tcr2))); // R5

  AST_MATCH_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (irq && match_time == $past(cmp))); // R6

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cont) |=> !armed); // R6

  AST_SNAP_ONLY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_event && !load_event) |=> irq); // R7

  AST_CONT_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cont) |=> (armed && cmp == add_mod($past(cmp), $past(period)))); // R8

  AST_COLLIDE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    load_event |=> (!irq && $stable(match_time))); // R10
endmodule

// File: rtl/oc_pin.sv
module oc_pin
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       cont,
  input  logic [1:0] act,
  output logic       pin
);
  function automatic logic pin_next(input logic cur, input logic [1:0] a, input logic c);
    if (c) return !cur;
    case (a)
      ACT_HIGH:   return 1'b1;
      ACT_LOW:    return 1'b0;
      ACT_TOGGLE: return !cur;
      default:    return cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   pin <= 1'b0;
    else if (hit) pin <= pin_next(pin, act, cont);
  end

  AST_CONT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cont) |=> (pin != $past(pin))); // R8

  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(pin)); // R9

  AST_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cont && act == ACT_HIGH) |=> pin); // R9
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int TW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW-1:0] wr_data,
  input  logic [TW-1:0] tcr1,
  input  logic [TW-1:0] tcr2,
  output logic [1:0]    req_o,
  output logic [TW-1:0] snap1_o,
  output logic [TW-1:0] snap2_o,
  output logic [TW-1:0] match_time_o,
  output logic          pin_o,
  output logic          irq_o
);
  ctrl_t         ctrl;
  logic [TW-1:0] offset, ref_time, period;
  logic          req_take, hit, cont;

  oc_regs #(.TW(TW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_take(req_take), .ctrl(ctrl), .offset(offset), .ref_time(ref_time),
    .period(period), .req(req_o)
  );

  oc_sched #(.TW(TW)) u_sched (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .offset(offset), .ref_time(ref_time),
    .period(period), .req(req_o), .tcr1(tcr1), .tcr2(tcr2), .req_take(req_take),
    .hit(hit), .cont(cont), .snap1(snap1_o), .snap2(snap2_o),
    .match_time(match_time_o), .irq(irq_o)
  );

  oc_pin u_pin (
    .clk(clk), .rst_n(rst_n), .hit(hit), .cont(cont), .act(ctrl.act), .pin(pin_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (req_o == REQ_NONE && !irq_o && !pin_o)); // R1

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(hit) || $past(req_take))); // R6
endmodule

// File: tb/tb_oc_channel.sv
module tb_oc_channel;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [TW-1:0] wr_data = '0;
  logic [TW-1:0] tcr1 = '0;
  logic [TW-1:0] tcr2 = '0;
  logic [1:0]    req_o;
  logic [TW-1:0] snap1_o, snap2_o, match_time_o;
  logic          pin_o, irq_o;

  int checks = 0;
  int errors = 0;
  logic pin_m = 1'b0;

  oc_channel dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tcr1(tcr1), .tcr2(tcr2), .req_o(req_o), .snap1_o(snap1_o), .snap2_o(snap2_o),
    .match_time_o(match_time_o), .pin_o(pin_o), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [TW-1:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  function automatic logic [TW-1:0] ctrl_w(input int act, input int tsel, input int so, input int prio);
    return TW'((prio << 4) | (so << 3) | (tsel << 2) | act);
  endfunction

  function automatic logic model_pin(input logic cur, input int act);
    case (act)
      1: return 1'b1;
      2: return 1'b0;
      3: return !cur;
      default: return cur;
    endcase
  endfunction

  task automatic single_run(input int act, input int tsel, input logic [TW-1:0] rf, input logic [TW-1:0] off);
    logic [TW-1:0] tgt;
    tgt = TW'((int'(rf) + int'(off)) % 65536);
    tcr1 = tgt ^ 16'h8000; tcr2 = tgt ^ 16'h4000;
    wr(3'd0, ctrl_w(act, tsel, 0, 1));
    wr(3'd1, off);
    wr(3'd2, rf);
    wr(3'd4, 16'h0001);
    chk(req_o == 2'b01, "R2 request accepted", req_o, 1);
    tick();
    chk(req_o == 2'b00, "R3 request cleared", req_o, 0);
    chk(snap1_o == (tgt ^ 16'h8000) && snap2_o == (tgt ^ 16'h4000), "R5 snapshots", snap1_o, tgt ^ 16'h8000);
    if (tsel == 1) begin tcr1 = tgt; tcr2 = tgt - 16'd1; end
    else begin tcr2 = tgt; tcr1 = tgt - 16'd1; end
    tick();
    chk(irq_o == 1'b0, "R11 unselected timebase no match", irq_o, 0);
    if (tsel == 1) begin tcr2 = tgt; tcr1 = tgt ^ 16'h8000; end
    else begin tcr1 = tgt; tcr2 = tgt ^ 16'h8000; end
    tick();
    pin_m = model_pin(pin_m, act);
    chk(irq_o == 1'b1, "R6 irq at match", irq_o, 1);
    chk(match_time_o == tgt, "R6 match time", match_time_o, tgt);
    chk(pin_o == pin_m, "R9 pin action", pin_o, pin_m);
    if (tsel == 1) tcr2 = tgt ^ 16'h0002; else tcr1 = tgt ^ 16'h0002;
    tick();
    chk(irq_o == 1'b0, "R6 irq one cycle", irq_o, 0);
    if (tsel == 1) tcr2 = tgt; else tcr1 = tgt;
    tick();
    chk(irq_o == 1'b0 && pin_o == pin_m, "R6 one-shot disarmed", irq_o, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [TW-1:0] first, tgt, oldc, newc;
    @(negedge clk);
    tick(); tick();
    rst_n = 1'b1;
    chk(req_o == 0, "R1 reset request", req_o, 0);
    chk(pin_o == 0 && irq_o == 0, "R1 reset pin irq", {pin_o, irq_o}, 0);
    chk(snap1_o == 0 && snap2_o == 0 && match_time_o == 0, "R1 reset records", snap1_o, 0);
    tcr1 = 16'h0000;
    tick();
    chk(irq_o == 0, "R1 nothing armed", irq_o, 0);

    for (int a = 0; a < 4; a++)
      for (int s = 0; s < 2; s++)
        for (int v = 0; v < 3; v++) begin
          case (v)
            0: single_run(a, s, 16'h0100, 16'h0023);
            1: single_run(a, s, 16'hFFF0, 16'h0020);
            default: single_run(a, s, 16'h7FFF, 16'h8001);
          endcase
        end

    // R7 snapshot-only
    wr(3'd0, ctrl_w(0, 0, 1, 3));
    wr(3'd1, 16'h0005);
    wr(3'd2, 16'h0010);
    tcr1 = 16'h1234; tcr2 = 16'hABCD;
    wr(3'd4, 16'h0001);
    tick();
    chk(irq_o == 1 && req_o == 0, "R7 snapshot-only irq", irq_o, 1);
    chk(snap1_o == 16'h1234 && snap2_o == 16'hABCD, "R7 snapshots", snap1_o, 16'h1234);
    tcr1 = 16'h0015;
    tick();
    chk(irq_o == 0, "R7 irq pulse ends", irq_o, 0);
    tick();
    chk(irq_o == 0 && pin_o == pin_m, "R7 no match armed", irq_o, 0);

    // R2 reserved code
    wr(3'd4, 16'h0002);
    tick();
    chk(req_o == 0 && irq_o == 0, "R2 code 10 cleared silently", req_o, 0);
    tick();
    chk(irq_o == 0 && snap1_o == 16'h1234, "R2 code 10 no effect", snap1_o, 16'h1234);

    // R4 priority zero holds
    wr(3'd0, ctrl_w(1, 0, 0, 0));
    wr(3'd4, 16'h0001);
    tick(); tick();
    chk(req_o == 2'b01, "R4 held without priority", req_o, 1);
    wr(3'd4, 16'h0003);
    chk(req_o == 2'b01, "R2 busy write ignored", req_o, 1);
    tcr1 = 16'h2222; tcr2 = 16'h3333;
    wr(3'd0, ctrl_w(1, 0, 0, 1));
    tick();
    chk(req_o == 0, "R4 taken after priority", req_o, 0);
    chk(snap1_o == 16'h2222 && snap2_o == 16'h3333, "R4 held code was single", snap1_o, 16'h2222);
    tcr1 = 16'h0015;
    tick();
    pin_m = 1'b1;
    chk(irq_o == 1 && pin_o == 1, "R4 held request matched", {irq_o, pin_o}, 3);

    // R8 continuous on second timebase
    tcr1 = 16'h5555; tcr2 = 16'h5555;
    wr(3'd0, ctrl_w(0, 1, 0, 2));
    wr(3'd1, 16'h1000);
    wr(3'd2, 16'hB000);
    wr(3'd3, 16'h4000);
    wr(3'd4, 16'h0003);
    tick();
    chk(req_o == 0, "R8 continuous taken", req_o, 0);
    first = 16'hC000;
    for (int n = 0; n < 5; n++) begin
      tgt = first + TW'(n * 16'h4000);
      tcr2 = tgt;
      tick();
      pin_m = !pin_m;
      chk(irq_o == 1 && match_time_o == tgt, "R8 periodic match", match_time_o, tgt);
      chk(pin_o == pin_m, "R8 pin toggles", pin_o, pin_m);
      tcr2 = tgt + 16'd1;
      tick();
      chk(irq_o == 0, "R8 irq pulse", irq_o, 0);
    end

    // R10 collision: new single request taken as old continuous match lands
    oldc = first + TW'(5 * 16'h4000);
    newc = 16'h3000 + 16'h0456;
    tcr2 = 16'h7777;
    wr(3'd0, ctrl_w(3, 1, 0, 1));
    wr(3'd1, 16'h0456);
    wr(3'd2, 16'h3000);
    wr(3'd4, 16'h0001);
    tcr2 = oldc;
    tick();
    chk(irq_o == 0 && pin_o == pin_m, "R10 old match dropped", irq_o, 0);
    chk(match_time_o == (oldc - 16'h4000), "R10 no time record", match_time_o, oldc - 16'h4000);
    tick();
    chk(irq_o == 0, "R10 old schedule gone", irq_o, 0);
    tcr2 = newc;
    tick();
    pin_m = !pin_m;
    chk(irq_o == 1 && match_time_o == newc && pin_o == pin_m, "R10 new schedule match", match_time_o, newc);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule